// File: doc/BRIEF.md
# Bitwise LUT Logic Unit

This execution unit computes an arbitrary bitwise function of two or three operands. For every bit position it collects the bit at that position from each operand into a small index. It then reads the selected truth table at that index. The result is registered. A single-cycle `done` pulse follows each `start` strobe by one clock, and the result stays in place until the next accepted request.

The unit has four modes.

- **Ternary immediate mode:** the eight-entry table is the immediate byte. The third input is the old destination value, so the operation overwrites the destination.
- **Binary register mode:** the four-entry table is a nibble of a table byte taken from a register. The table changes at run time.
- **Binary field mode:** the four-entry table is one of the four-bit fields of a condition register.
- **Field-ternary mode:** the immediate table is applied to three condition fields. The result is merged into a destination field under a four-bit write mask, and the updated condition register is returned.

Top module: `lut_logic_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and `result` is all zeros.
- R2: `done` is 1 exactly in the cycle after a cycle in which `start` was sampled high outside reset. `result` changes only in such cycles and otherwise holds its value.
- R3: In mode 0 (ternary), result bit i equals `imm[4*opnd_dst[i] + 2*opnd_a[i] + opnd_b[i]]`.
- R4: In mode 1 (binary register), the table is `tbl_byte[3:0]` when `nib_hi` is 0 and `tbl_byte[7:4]` when `nib_hi` is 1. Result bit i equals `table[2*opnd_a[i] + opnd_b[i]]`.
- R5: In mode 2 (binary field), the table is condition field k = `fld_c_sel`, that is `cond_reg[4k+3:4k]`. Result bit i equals `table[2*opnd_a[i] + opnd_b[i]]`.
- R6: In mode 3 (field ternary), j runs from 0 to 3, and field k is bits `cond_reg[4k+3:4k]`.
  - Let a, b and c be bit j of the fields chosen by `fld_a_sel`, `fld_b_sel` and `fld_c_sel`.
  - Where `fld_mask[j]` is 1, bit j of the field chosen by `fld_dst_sel` becomes `imm[4c+2b+a]`.
  - All other condition bits keep their input value.
  - `result[31:0]` is the updated condition register and the upper bits of `result` are 0.
- R7: In modes 1 and 2, the value of `imm` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; operands are sampled on this edge |
| mode | input | 2 | 0 ternary, 1 binary register, 2 binary field, 3 field ternary |
| opnd_a | input | 64 | First operand (index bit 1) |
| opnd_b | input | 64 | Second operand (index bit 0) |
| opnd_dst | input | 64 | Old destination value (index bit 2 in mode 0) |
| tbl_byte | input | 8 | Low byte of the table register for mode 1 |
| imm | input | 8 | Eight-entry truth table for modes 0 and 3 |
| nib_hi | input | 1 | Selects the high nibble of `tbl_byte` in mode 1 |
| cond_reg | input | 32 | Condition register of eight four-bit fields |
| fld_a_sel | input | 3 | Field supplying index bit 0 in mode 3 |
| fld_b_sel | input | 3 | Field supplying index bit 1 in mode 3 |
| fld_c_sel | input | 3 | Field supplying index bit 2 in mode 3; table field in mode 2 |
| fld_dst_sel | input | 3 | Destination field in mode 3 |
| fld_mask | input | 4 | Per-bit write enable for the destination field in mode 3 |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered result |

## Verification
The assertions assume that `start` is sampled only when the operand, mode and select inputs are valid for that cycle. They also assume that inputs driven during reset need not produce any output.

The bench changes inputs only on the falling edge, so every value seen on a rising edge is stable. It issues requests back to back as well as with idle gaps, so the hold behaviour is exercised between results.

The bench covers all 256 immediates, both nibble selections, every table field, and randomised field selects and masks, including a zero mask. A constant-one table and a zero mask give the assertions fixed outcomes that the bench stimulus is certain to reach.

// File: rtl/lut_pkg.sv
package lut_pkg;

    localparam int LUT2_N = 4;
    localparam int LUT3_N = 8;

    typedef enum logic [1:0] {
        LM_TERN     = 2'd0,
        LM_BIN_REG  = 2'd1,
        LM_BIN_FLD  = 2'd2,
        LM_FLD_TERN = 2'd3
    } lut_mode_e;

    // Table chosen for the bit array plus whether the destination feeds index bit 2
    typedef struct packed {
        logic [LUT3_N-1:0] tbl;
        logic              use_dst;
    } tbl_sel_t;

    function automatic logic lut_pick(input logic [LUT3_N-1:0] t,
                                      input logic hi, input logic mid, input logic lo);
        return t[{hi, mid, lo}];
    endfunction

endpackage

// File: rtl/lut_table_sel.sv
module lut_table_sel
    import lut_pkg::*;
#(
    parameter int FLD_N = 8,
    localparam int COND_W = LUT2_N * FLD_N,
    localparam int FSEL_W = $clog2(FLD_N)
) (
    input  lut_mode_e          mode,
    input  logic [7:0]         imm,
    input  logic [7:0]         tbl_byte,
    input  logic               nib_hi,
    input  logic [COND_W-1:0]  cond_reg,
    input  logic [FSEL_W-1:0]  fsel,
    output tbl_sel_t           sel
);
    logic [LUT2_N-1:0] nib;
    logic [LUT2_N-1:0] fld;

    assign nib = nib_hi ? tbl_byte[7:4] : tbl_byte[3:0];
    assign fld = cond_reg[int'(fsel)*LUT2_N +: LUT2_N];

    always_comb begin
        sel.use_dst = 1'b0;
        sel.tbl     = '0;
        unique case (mode)
            LM_TERN: begin
                sel.tbl     = imm;
                sel.use_dst = 1'b1;
            end
            LM_BIN_REG:  sel.tbl = {{(LUT3_N-LUT2_N){1'b0}}, nib};
            LM_BIN_FLD:  sel.tbl = {{(LUT3_N-LUT2_N){1'b0}}, fld};
            default:     sel.tbl = imm;
        endcase
    end
endmodule

// File: rtl/lut_bit_array.sv
module lut_bit_array
    import lut_pkg::*;
#(
    parameter int W = 64
) (
    input  tbl_sel_t      sel,
    input  logic [W-1:0]  a_vec,
    input  logic [W-1:0]  b_vec,
    input  logic [W-1:0]  d_vec,
    output logic [W-1:0]  y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = lut_pick(sel.tbl, sel.use_dst & d_vec[i], a_vec[i], b_vec[i]);
    end
endmodule

// File: rtl/lut_field_unit.sv
module lut_field_unit
    import lut_pkg::*;
#(
    parameter int FLD_N = 8,
    localparam int COND_W = LUT2_N * FLD_N,
    localparam int FSEL_W = $clog2(FLD_N)
) (
    input  logic [COND_W-1:0] cond_reg,
    input  logic [7:0]        imm,
    input  logic [FSEL_W-1:0] sa,
    input  logic [FSEL_W-1:0] sb,
    input  logic [FSEL_W-1:0] sc,
    input  logic [FSEL_W-1:0] sd,
    input  logic [LUT2_N-1:0] mask,
    output logic [COND_W-1:0] cond_new
);
    logic [LUT2_N-1:0] fa, fb, fc, fd, merged;

    assign fa = cond_reg[int'(sa)*LUT2_N +: LUT2_N];
    assign fb = cond_reg[int'(sb)*LUT2_N +: LUT2_N];
    assign fc = cond_reg[int'(sc)*LUT2_N +: LUT2_N];
    assign fd = cond_reg[int'(sd)*LUT2_N +: LUT2_N];

    for (genvar j = 0; j < LUT2_N; j++) begin : g_lane
        assign merged[j] = mask[j] ? lut_pick(imm, fc[j], fb[j], fa[j]) : fd[j];
    end

    for (genvar k = 0; k < FLD_N; k++) begin : g_fld
        assign cond_new[k*LUT2_N +: LUT2_N] =
            (sd == FSEL_W'(k)) ? merged : cond_reg[k*LUT2_N +: LUT2_N];
    end
endmodule

// File: rtl/lut_logic_unit.sv
module lut_logic_unit
    import lut_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FLD_N  = 8,
    localparam int COND_W = LUT2_N * FLD_N,
    localparam int FSEL_W = $clog2(FLD_N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [DATA_W-1:0]  opnd_dst,
    input  logic [7:0]         tbl_byte,
    input  logic [7:0]         imm,
    input  logic               nib_hi,
    input  logic [COND_W-1:0]  cond_reg,
    input  logic [FSEL_W-1:0]  fld_a_sel,
    input  logic [FSEL_W-1:0]  fld_b_sel,
    input  logic [FSEL_W-1:0]  fld_c_sel,
    input  logic [FSEL_W-1:0]  fld_dst_sel,
    input  logic [LUT2_N-1:0]  fld_mask,
    output logic               done,
    output logic [DATA_W-1:0]  result
);
    lut_mode_e          mode_e;
    tbl_sel_t           tsel;
    logic [DATA_W-1:0]  word_y;
    logic [COND_W-1:0]  cond_y;
    logic [DATA_W-1:0]  next_res;

    assign mode_e = lut_mode_e'(mode);

    lut_table_sel #(.FLD_N(FLD_N)) u_tsel (
        .mode     (mode_e),
        .imm      (imm),
        .tbl_byte (tbl_byte),
        .nib_hi   (nib_hi),
        .cond_reg (cond_reg),
        .fsel     (fld_c_sel),
        .sel      (tsel)
    );

    lut_bit_array #(.W(DATA_W)) u_bits (
        .sel   (tsel),
        .a_vec (opnd_a),
        .b_vec (opnd_b),
        .d_vec (opnd_dst),
        .y     (word_y)
    );

    lut_field_unit #(.FLD_N(FLD_N)) u_fld (
        .cond_reg (cond_reg),
        .imm      (imm),
        .sa       (fld_a_sel),
        .sb       (fld_b_sel),
        .sc       (fld_c_sel),
        .sd       (fld_dst_sel),
        .mask     (fld_mask),
        .cond_new (cond_y)
    );

    assign next_res = (mode_e == LM_FLD_TERN) ? {{(DATA_W-COND_W){1'b0}}, cond_y} : word_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= start;
            if (start) result <= next_res;
        end
    end
endmodule

// File: rtl/lut_logic_chk.sv
module lut_logic_chk #(
    parameter int DATA_W = 64,
    parameter int COND_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [1:0]        mode,
    input logic [7:0]        tbl_byte,
    input logic              nib_hi,
    input logic [COND_W-1:0] cond_reg,
    input logic [3:0]        fld_mask,
    input logic              done,
    input logic [DATA_W-1:0] result
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done && result == '0));

    p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_done_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    p_ones_table_r4: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'd1 && (nib_hi ? tbl_byte[7:4] : tbl_byte[3:0]) == 4'hF)
        |=> result == {DATA_W{1'b1}});

    p_mask_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (start && mode == 2'd3 && fld_mask == 4'h0)
        |=> (result[COND_W-1:0] == $past(cond_reg) && result[DATA_W-1:COND_W] == '0));
endmodule

bind lut_logic_unit lut_logic_chk #(.DATA_W(DATA_W), .COND_W(COND_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .tbl_byte (tbl_byte),
    .nib_hi   (nib_hi),
    .cond_reg (cond_reg),
    .fld_mask (fld_mask),
    .done     (done),
    .result   (result)
);

// File: tb/sim_lut_logic_unit.sv
module sim_lut_logic_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] opnd_a = '0, opnd_b = '0, opnd_dst = '0;
    logic [7:0]  tbl_byte = '0, imm = '0;
    logic        nib_hi = 1'b0;
    logic [31:0] cond_reg = '0;
    logic [2:0]  fld_a_sel = '0, fld_b_sel = '0, fld_c_sel = '0, fld_dst_sel = '0;
    logic [3:0]  fld_mask = '0;
    logic        done;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        exp_done = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R1";

    always #10 clk = ~clk;

    lut_logic_unit u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_dst(opnd_dst),
        .tbl_byte(tbl_byte), .imm(imm), .nib_hi(nib_hi), .cond_reg(cond_reg),
        .fld_a_sel(fld_a_sel), .fld_b_sel(fld_b_sel), .fld_c_sel(fld_c_sel),
        .fld_dst_sel(fld_dst_sel), .fld_mask(fld_mask),
        .done(done), .result(result)
    );

    function automatic logic [63:0] ref_calc();
        logic [63:0] r = '0;
        logic [3:0]  t;
        int idx;
        case (mode)
            2'd0: for (int i = 0; i < 64; i++) begin
                idx = (opnd_dst[i] ? 4 : 0) + (opnd_a[i] ? 2 : 0) + (opnd_b[i] ? 1 : 0);
                r[i] = imm[idx];
            end
            2'd1, 2'd2: begin
                if (mode == 2'd1) t = nib_hi ? tbl_byte[7:4] : tbl_byte[3:0];
                else              t = cond_reg[int'(fld_c_sel)*4 +: 4];
                for (int i = 0; i < 64; i++) begin
                    idx = (opnd_a[i] ? 2 : 0) + (opnd_b[i] ? 1 : 0);
                    r[i] = t[idx];
                end
            end
            default: begin
                r[31:0] = cond_reg;
                for (int j = 0; j < 4; j++) begin
                    idx = (cond_reg[int'(fld_c_sel)*4+j] ? 4 : 0)
                        + (cond_reg[int'(fld_b_sel)*4+j] ? 2 : 0)
                        + (cond_reg[int'(fld_a_sel)*4+j] ? 1 : 0);
                    if (fld_mask[j]) r[int'(fld_dst_sel)*4+j] = imm[idx];
                end
            end
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reference model: advances on the rising edge from inputs that are stable there
    always @(posedge clk) begin
        if (rst) begin
            exp_done <= 1'b0;
            exp_res  <= '0;
            exp_tag  <= "R1";
        end else begin
            exp_done <= start;
            if (start) begin
                exp_res <= ref_calc();
                exp_tag <= tag_of(mode);
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (done !== exp_done) begin
                errors++;
                $display("FAIL R2 done actual=%0b expected=%0b", done, exp_done);
            end
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
            end
        end
    end

    task automatic rand_ops();
        opnd_a   = {$urandom, $urandom};
        opnd_b   = {$urandom, $urandom};
        opnd_dst = {$urandom, $urandom};
        tbl_byte = 8'($urandom);
        cond_reg = $urandom;
    endtask

    task automatic issue();
        start = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [63:0] r_first;
        @(negedge clk);
        // R1: reset holds, with a start strobe during reset ignored
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 actual=%0b/%h expected=0/0", done, result);
        end

        // R3: every immediate on random operands, back to back
        mode = 2'd0;
        for (int k = 0; k < 256; k++) begin
            rand_ops();
            imm = 8'(k);
            issue();
        end
        idle(3);

        // R4: both nibble selections, including constant-one tables
        mode = 2'd1;
        for (int k = 0; k < 64; k++) begin
            rand_ops();
            nib_hi = k[0];
            if (k % 16 == 5) tbl_byte = 8'hFF;
            issue();
            if (k % 8 == 0) idle(2);
        end
        idle(2);

        // R5: every table field
        mode = 2'd2;
        for (int k = 0; k < 64; k++) begin
            rand_ops();
            fld_c_sel = 3'(k);
            issue();
        end
        idle(2);

        // R6: random field selects, masks (some zero)
        mode = 2'd3;
        for (int k = 0; k < 300; k++) begin
            rand_ops();
            imm = 8'($urandom);
            fld_a_sel = 3'($urandom);
            fld_b_sel = 3'($urandom);
            fld_c_sel = 3'($urandom);
            fld_dst_sel = 3'($urandom);
            fld_mask = (k % 10 == 0) ? 4'h0 : 4'($urandom);
            issue();
        end
        idle(2);

        // R7: immediate does not influence the binary modes
        for (int m = 1; m <= 2; m++) begin
            mode = 2'(m);
            rand_ops();
            imm = 8'h00;
            issue();
            r_first = result;
            imm = 8'hFF;
            issue();
            checks++;
            if (result !== r_first) begin
                errors++;
                $display("FAIL R7 actual=%h expected=%h", result, r_first);
            end
            idle(1);
        end

        idle(3);
        summary();
    end
endmodule